// File: doc/BRIEF.md
# Per-Port Pin Configuration Register Bank

This block holds the multiplexing and pad settings for a row of I/O ports of 32 pins each. Software reaches it through a plain single-cycle register bus: a byte address, a write strobe, a 32-bit write word and a 32-bit read word. Each port owns its own 256-byte window. A port's register offset, and the port index taken from the address bits above it, select one of ten full-word registers. Bits 1:0 of the address are ignored, and every write replaces the whole word.

Four controls use one bit per pin, and the bit position equals the pin's number inside its port. These are direction, GPIO-in-use, pull-up enable and alternate-function select. Three controls use two bits per pin: output configuration, input configuration A and input configuration B. Each of these takes a pair of adjacent registers. Pins 0 to 15 sit in the lower register and pins 16 to 31 in the one four bytes above it. Inside each register, a pin's field starts at bit (pin mod 16) x 2. The stored values drive flat per-pin output vectors, indexed by global pin number = port x 32 + local pin. The two-bit vectors give each pin a field two bits wide.

Top module: `pin_cfg_bank`

## Requirements
- R1: After reset every register reads zero and every per-pin output is zero.
- R2: The one-bit controls sit at port offsets 0x00 (direction), 0x1C (GPIO-in-use), 0x20 (pull-up enable) and 0x38 (function select). Bit b of each of these registers drives output bit port x 32 + b of pin_dir, pin_gpio, pin_pull and pin_fsel respectively.
- R3: Output configuration uses offset 0x04 for local pins 0 to 15 and offset 0x08 for local pins 16 to 31. A pin's field is bits [(p mod 16) x 2 + 1 : (p mod 16) x 2] of its register. The field drives pin_ocfg bits [2g+1:2g], where g is the global pin number.
- R4: Input configuration A uses offsets 0x0C and 0x10, and input configuration B uses offsets 0x14 and 0x18. Both follow the same lower/upper split and field placement as R3, and they drive pin_icfga and pin_icfgb.
- R5: Port windows are spaced 0x100 bytes apart, and the port index is address bits [ADDR_W-1:8]. A write to one port's window leaves every other port's registers and outputs unchanged.
- R6: A read is combinational. bus_rdata shows the stored value of the addressed register in the same cycle the address is presented, with no clock edge needed.
- R7: An unmapped address reads zero and a write to it changes nothing. Unmapped means any offset other than the ten listed in R2 to R4, or any port index at or above NUM_PORTS.
- R8: A write takes effect at the clock edge where bus_we is high, and not before. With bus_we low, all registers hold, whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; ADDR_W = 8 + clog2(NUM_PORTS) |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_dir | output | NUM_PORTS*32 | Direction per pin |
| pin_gpio | output | NUM_PORTS*32 | GPIO-in-use per pin |
| pin_pull | output | NUM_PORTS*32 | Pull-up enable per pin |
| pin_fsel | output | NUM_PORTS*32 | Alternate-function select per pin |
| pin_ocfg | output | NUM_PORTS*64 | Output configuration, 2 bits per pin |
| pin_icfga | output | NUM_PORTS*64 | Input configuration A, 2 bits per pin |
| pin_icfgb | output | NUM_PORTS*64 | Input configuration B, 2 bits per pin |

## Verification
The bench builds the bank with NUM_PORTS = 3, which gives a 10-bit address. The fourth port window (port index 3) therefore falls inside the address space but maps to no port. With this setting, the out-of-range port check of R7 can be reached alongside unmapped offsets inside real ports. Three ports also let a write to the middle port be checked for leaks into both of its neighbours. The two-bit split is probed at local pins 0, 15, 16 and 31 of different ports.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;

    localparam int WORD_W    = 32;
    localparam int PORT_PINS = 32;
    localparam int WIN_BITS  = 8;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_DIR,
        REG_OCFG_LO,
        REG_OCFG_HI,
        REG_ICFGA_LO,
        REG_ICFGA_HI,
        REG_ICFGB_LO,
        REG_ICFGB_HI,
        REG_GPIO,
        REG_PULL,
        REG_FSEL
    } reg_id_e;

    // word offsets inside a port window
    localparam logic [5:0] WOFS_DIR      = 6'h00;
    localparam logic [5:0] WOFS_OCFG_LO  = 6'h01;
    localparam logic [5:0] WOFS_OCFG_HI  = 6'h02;
    localparam logic [5:0] WOFS_ICFGA_LO = 6'h03;
    localparam logic [5:0] WOFS_ICFGA_HI = 6'h04;
    localparam logic [5:0] WOFS_ICFGB_LO = 6'h05;
    localparam logic [5:0] WOFS_ICFGB_HI = 6'h06;
    localparam logic [5:0] WOFS_GPIO     = 6'h07;
    localparam logic [5:0] WOFS_PULL     = 6'h08;
    localparam logic [5:0] WOFS_FSEL     = 6'h0E;

    typedef struct packed {
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] ocfg_lo;
        logic [WORD_W-1:0] ocfg_hi;
        logic [WORD_W-1:0] icfga_lo;
        logic [WORD_W-1:0] icfga_hi;
        logic [WORD_W-1:0] icfgb_lo;
        logic [WORD_W-1:0] icfgb_hi;
        logic [WORD_W-1:0] gpio;
        logic [WORD_W-1:0] pull;
        logic [WORD_W-1:0] fsel;
    } port_regs_t;

endpackage

// File: rtl/pincfg_decode.sv
module pincfg_decode
    import pincfg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 10,
    parameter int PW        = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PW-1:0]     port_idx,
    output reg_id_e           reg_id,
    output logic              hit
);

    localparam int PORT_BITS = ADDR_W - WIN_BITS;

    logic       port_ok;
    logic [5:0] word_ofs;
    logic       unused_lsb;

    assign word_ofs   = addr[WIN_BITS-1:2];
    assign unused_lsb = ^addr[1:0];

    generate
        if (PORT_BITS > 0) begin : g_multi
            assign port_idx = addr[ADDR_W-1:WIN_BITS];
            assign port_ok  = (int'(addr[ADDR_W-1:WIN_BITS]) < NUM_PORTS);
        end else begin : g_single
            assign port_idx = '0;
            assign port_ok  = 1'b1;
        end
    endgenerate

    always_comb begin
        unique case (word_ofs)
            WOFS_DIR:      reg_id = REG_DIR;
            WOFS_OCFG_LO:  reg_id = REG_OCFG_LO;
            WOFS_OCFG_HI:  reg_id = REG_OCFG_HI;
            WOFS_ICFGA_LO: reg_id = REG_ICFGA_LO;
            WOFS_ICFGA_HI: reg_id = REG_ICFGA_HI;
            WOFS_ICFGB_LO: reg_id = REG_ICFGB_LO;
            WOFS_ICFGB_HI: reg_id = REG_ICFGB_HI;
            WOFS_GPIO:     reg_id = REG_GPIO;
            WOFS_PULL:     reg_id = REG_PULL;
            WOFS_FSEL:     reg_id = REG_FSEL;
            default:       reg_id = REG_NONE;
        endcase
    end

    assign hit = port_ok && (reg_id != REG_NONE);

endmodule

// File: rtl/pincfg_port.sv
module pincfg_port
    import pincfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  reg_id_e               reg_sel,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    output logic [PORT_PINS-1:0]  dir_o,
    output logic [PORT_PINS-1:0]  gpio_o,
    output logic [PORT_PINS-1:0]  pull_o,
    output logic [PORT_PINS-1:0]  fsel_o,
    output logic [2*PORT_PINS-1:0] ocfg_o,
    output logic [2*PORT_PINS-1:0] icfga_o,
    output logic [2*PORT_PINS-1:0] icfgb_o
);

    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (reg_sel)
                REG_DIR:      regs_d.dir      = wdata;
                REG_OCFG_LO:  regs_d.ocfg_lo  = wdata;
                REG_OCFG_HI:  regs_d.ocfg_hi  = wdata;
                REG_ICFGA_LO: regs_d.icfga_lo = wdata;
                REG_ICFGA_HI: regs_d.icfga_hi = wdata;
                REG_ICFGB_LO: regs_d.icfgb_lo = wdata;
                REG_ICFGB_HI: regs_d.icfgb_hi = wdata;
                REG_GPIO:     regs_d.gpio     = wdata;
                REG_PULL:     regs_d.pull     = wdata;
                REG_FSEL:     regs_d.fsel     = wdata;
                default:      regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_DIR:      rdata = regs_q.dir;
            REG_OCFG_LO:  rdata = regs_q.ocfg_lo;
            REG_OCFG_HI:  rdata = regs_q.ocfg_hi;
            REG_ICFGA_LO: rdata = regs_q.icfga_lo;
            REG_ICFGA_HI: rdata = regs_q.icfga_hi;
            REG_ICFGB_LO: rdata = regs_q.icfgb_lo;
            REG_ICFGB_HI: rdata = regs_q.icfgb_hi;
            REG_GPIO:     rdata = regs_q.gpio;
            REG_PULL:     rdata = regs_q.pull;
            REG_FSEL:     rdata = regs_q.fsel;
            default:      rdata = '0;
        endcase
    end

    assign dir_o  = regs_q.dir;
    assign gpio_o = regs_q.gpio;
    assign pull_o = regs_q.pull;
    assign fsel_o = regs_q.fsel;

    // lower register covers local pins 0..15, upper covers 16..31
    assign ocfg_o  = {regs_q.ocfg_hi,  regs_q.ocfg_lo};
    assign icfga_o = {regs_q.icfga_hi, regs_q.icfga_lo};
    assign icfgb_o = {regs_q.icfgb_hi, regs_q.icfgb_lo};

endmodule

// File: rtl/pincfg_rdmux.sv
module pincfg_rdmux
    import pincfg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PW        = 2
) (
    input  logic [NUM_PORTS*WORD_W-1:0] port_rd,
    input  logic [PW-1:0]               port_idx,
    input  logic                        hit,
    output logic [WORD_W-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_PORTS; g++) begin
            if (hit && (port_idx == PW'(g))) begin
                rdata = port_rd[g*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
    import pincfg_pkg::*;
#(
    parameter  int NUM_PORTS = 4,
    localparam int PORT_BITS = $clog2(NUM_PORTS),
    localparam int ADDR_W    = WIN_BITS + PORT_BITS,
    localparam int NPINS     = NUM_PORTS * PORT_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NPINS-1:0]  pin_dir,
    output logic [NPINS-1:0]  pin_gpio,
    output logic [NPINS-1:0]  pin_pull,
    output logic [NPINS-1:0]  pin_fsel,
    output logic [2*NPINS-1:0] pin_ocfg,
    output logic [2*NPINS-1:0] pin_icfga,
    output logic [2*NPINS-1:0] pin_icfgb
);

    localparam int PW = (PORT_BITS > 0) ? PORT_BITS : 1;

    logic [PW-1:0]               port_idx;
    reg_id_e                     reg_id;
    logic                        hit;
    logic [NUM_PORTS*WORD_W-1:0] port_rd;

    pincfg_decode #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .PW        (PW)
    ) u_dec (
        .addr     (bus_addr),
        .port_idx (port_idx),
        .reg_id   (reg_id),
        .hit      (hit)
    );

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
            logic sel;
            assign sel = hit && (port_idx == PW'(g));

            pincfg_port u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (sel && bus_we),
                .reg_sel (reg_id),
                .wdata   (bus_wdata),
                .rdata   (port_rd[g*WORD_W +: WORD_W]),
                .dir_o   (pin_dir[g*PORT_PINS +: PORT_PINS]),
                .gpio_o  (pin_gpio[g*PORT_PINS +: PORT_PINS]),
                .pull_o  (pin_pull[g*PORT_PINS +: PORT_PINS]),
                .fsel_o  (pin_fsel[g*PORT_PINS +: PORT_PINS]),
                .ocfg_o  (pin_ocfg[g*2*PORT_PINS +: 2*PORT_PINS]),
                .icfga_o (pin_icfga[g*2*PORT_PINS +: 2*PORT_PINS]),
                .icfgb_o (pin_icfgb[g*2*PORT_PINS +: 2*PORT_PINS])
            );
        end
    endgenerate

    pincfg_rdmux #(
        .NUM_PORTS (NUM_PORTS),
        .PW        (PW)
    ) u_rd (
        .port_rd  (port_rd),
        .port_idx (port_idx),
        .hit      (hit),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/pin_cfg_bank_chk.sv
module pin_cfg_bank_chk #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 10,
    parameter int NPINS     = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pin_dir,
    input logic [NPINS-1:0]  pin_gpio,
    input logic [NPINS-1:0]  pin_pull,
    input logic [NPINS-1:0]  pin_fsel,
    input logic [2*NPINS-1:0] pin_ocfg,
    input logic [2*NPINS-1:0] pin_icfga,
    input logic [2*NPINS-1:0] pin_icfgb
);

    logic [10*NPINS-1:0] all_out;
    logic                mapped;
    int                  port_n;
    int                  wofs;

    assign all_out = {pin_dir, pin_gpio, pin_pull, pin_fsel,
                      pin_ocfg, pin_icfga, pin_icfgb};

    always_comb begin
        port_n = int'(bus_addr) / 256;
        wofs   = (int'(bus_addr) % 256) / 4;
        mapped = (port_n < NUM_PORTS) && ((wofs <= 8) || (wofs == 14));
    end

    // R7: unmapped address reads zero
    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == 32'h0));

    // R7: write to unmapped address changes no output
    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> $stable(all_out));

    // R8: no write strobe means every output holds
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(all_out));

    // R6: a word written to a mapped register reads back next cycle
    assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && mapped) |=>
            ((bus_addr[ADDR_W-1:2] != $past(bus_addr[ADDR_W-1:2])) ||
             (bus_rdata == $past(bus_wdata))));

endmodule

bind pin_cfg_bank pin_cfg_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .NPINS     (NPINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_dir   (pin_dir),
    .pin_gpio  (pin_gpio),
    .pin_pull  (pin_pull),
    .pin_fsel  (pin_fsel),
    .pin_ocfg  (pin_ocfg),
    .pin_icfga (pin_icfga),
    .pin_icfgb (pin_icfgb)
);

// File: tb/sim_pin_cfg_bank.sv
module sim_pin_cfg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NP    = 3;
    localparam int AW    = 10;
    localparam int NPINS = NP * 32;
    localparam int NREG  = 10;
    // byte offsets: dir, ocfg lo/hi, icfga lo/hi, icfgb lo/hi, gpio, pull, fsel
    localparam logic [7:0] OFS [NREG] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
                                         8'h14, 8'h18, 8'h1C, 8'h20, 8'h38};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPINS-1:0]  pin_dir, pin_gpio, pin_pull, pin_fsel;
    logic [2*NPINS-1:0] pin_ocfg, pin_icfga, pin_icfgb;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [31:0] mdl [NP][NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_cfg_bank #(.NUM_PORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_dir(pin_dir), .pin_gpio(pin_gpio), .pin_pull(pin_pull),
        .pin_fsel(pin_fsel), .pin_ocfg(pin_ocfg), .pin_icfga(pin_icfga),
        .pin_icfgb(pin_icfgb)
    );

    function automatic logic [AW-1:0] mk(int p, int r);
        return AW'(p * 256 + int'(OFS[r]));
    endfunction

    task automatic chk(string req, string what, logic [191:0] act, logic [191:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        #1;
    endtask

    task automatic mwr(int p, int r, logic [31:0] d);
        wr(mk(p, r), d);
        mdl[p][r] = d;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_state(string req);
        logic [31:0]        v;
        logic [NPINS-1:0]   e_dir, e_gpio, e_pull, e_fsel;
        logic [2*NPINS-1:0] e_oc, e_ia, e_ib;
        for (int p = 0; p < NP; p++) begin
            for (int r = 0; r < NREG; r++) begin
                rd(mk(p, r), v);
                chk(req, $sformatf("read p%0d ofs %h", p, OFS[r]), 192'(v), 192'(mdl[p][r]));
            end
            e_dir[p*32 +: 32]  = mdl[p][0];
            e_gpio[p*32 +: 32] = mdl[p][7];
            e_pull[p*32 +: 32] = mdl[p][8];
            e_fsel[p*32 +: 32] = mdl[p][9];
            for (int q = 0; q < 32; q++) begin
                int ri;
                int b;
                ri = (q < 16) ? 0 : 1;
                b  = (q % 16) * 2;
                e_oc[(p*32+q)*2 +: 2] = mdl[p][1+ri][b +: 2];
                e_ia[(p*32+q)*2 +: 2] = mdl[p][3+ri][b +: 2];
                e_ib[(p*32+q)*2 +: 2] = mdl[p][5+ri][b +: 2];
            end
        end
        chk(req, "pin_dir",   192'(pin_dir),   192'(e_dir));
        chk(req, "pin_gpio",  192'(pin_gpio),  192'(e_gpio));
        chk(req, "pin_pull",  192'(pin_pull),  192'(e_pull));
        chk(req, "pin_fsel",  192'(pin_fsel),  192'(e_fsel));
        chk(req, "pin_ocfg",  192'(pin_ocfg),  192'(e_oc));
        chk(req, "pin_icfga", 192'(pin_icfga), 192'(e_ia));
        chk(req, "pin_icfgb", 192'(pin_icfgb), 192'(e_ib));
    endtask

    task automatic t_reset();
        chk("R1", "pin_dir at reset", 192'(pin_dir), 192'(0));
        chk("R1", "pin_ocfg at reset", 192'(pin_ocfg), 192'(0));
        check_state("R1");
    endtask

    task automatic t_one_bit();
        mwr(1, 0, 32'hA5A5_0001);
        chk("R2", "dir pin 32", 192'(pin_dir[32]), 192'(1));
        chk("R2", "dir pin 63", 192'(pin_dir[63]), 192'(1));
        chk("R2", "dir pin 33", 192'(pin_dir[33]), 192'(0));
        mwr(0, 7, 32'h8000_0001);
        chk("R2", "gpio pin 31", 192'(pin_gpio[31]), 192'(1));
        mwr(2, 8, 32'h0001_0000);
        chk("R2", "pull pin 80", 192'(pin_pull[80]), 192'(1));
        mwr(0, 9, 32'h0000_0100);
        chk("R2", "fsel pin 8", 192'(pin_fsel[8]), 192'(1));
        check_state("R2");
    endtask

    task automatic t_two_bit();
        mwr(0, 1, 32'h0000_0003);
        chk("R3", "ocfg pin 0", 192'(pin_ocfg[1:0]), 192'(3));
        mwr(0, 2, 32'hC000_0002);
        chk("R3", "ocfg pin 16", 192'(pin_ocfg[33:32]), 192'(2));
        chk("R3", "ocfg pin 31", 192'(pin_ocfg[63:62]), 192'(3));
        mwr(1, 1, 32'h4000_0000);
        chk("R3", "ocfg pin 47", 192'(pin_ocfg[95:94]), 192'(1));
        chk("R3", "ocfg pin 48", 192'(pin_ocfg[97:96]), 192'(0));
        check_state("R3");
    endtask

    task automatic t_input_cfg();
        mwr(2, 3, 32'h0000_0004);
        chk("R4", "icfga pin 65", 192'(pin_icfga[131:130]), 192'(1));
        mwr(2, 4, 32'h0000_0001);
        chk("R4", "icfga pin 80", 192'(pin_icfga[161:160]), 192'(1));
        mwr(1, 5, 32'h8000_0000);
        chk("R4", "icfgb pin 47", 192'(pin_icfgb[95:94]), 192'(2));
        mwr(1, 6, 32'h0000_000C);
        chk("R4", "icfgb pin 49", 192'(pin_icfgb[99:98]), 192'(3));
        check_state("R4");
    endtask

    task automatic t_port_isolation();
        mwr(0, 0, 32'hFFFF_FFFF);
        mwr(2, 0, 32'h0000_0000);
        chk("R5", "port1 dir untouched", 192'(pin_dir[63:32]), 192'(mdl[1][0]));
        chk("R5", "port0 dir", 192'(pin_dir[31:0]), 192'(32'hFFFF_FFFF));
        mwr(1, 7, 32'h1234_5678);
        chk("R5", "port0 gpio untouched", 192'(pin_gpio[31:0]), 192'(mdl[0][7]));
        chk("R5", "port2 gpio untouched", 192'(pin_gpio[95:64]), 192'(mdl[2][7]));
        check_state("R5");
    endtask

    task automatic t_comb_read();
        @(negedge clk);
        bus_addr = mk(1, 0);
        #1;
        chk("R6", "read p1 dir", 192'(bus_rdata), 192'(mdl[1][0]));
        bus_addr = mk(1, 7);
        #1;
        chk("R6", "read p1 gpio same cycle", 192'(bus_rdata), 192'(mdl[1][7]));
        bus_addr = mk(0, 2);
        #1;
        chk("R6", "read p0 ocfg hi same cycle", 192'(bus_rdata), 192'(mdl[0][2]));
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(AW'(10'h024), 32'hDEAD_BEEF);
        wr(AW'(10'h03C), 32'hDEAD_BEEF);
        wr(AW'(10'h1FC), 32'hDEAD_BEEF);
        wr(AW'(10'h300), 32'hDEAD_BEEF);
        wr(AW'(10'h338), 32'hDEAD_BEEF);
        rd(AW'(10'h024), v);
        chk("R7", "read p0 0x24", 192'(v), 192'(0));
        rd(AW'(10'h1FC), v);
        chk("R7", "read p1 0xFC", 192'(v), 192'(0));
        rd(AW'(10'h300), v);
        chk("R7", "read p3 0x00", 192'(v), 192'(0));
        rd(AW'(10'h338), v);
        chk("R7", "read p3 0x38", 192'(v), 192'(0));
        check_state("R7");
    endtask

    task automatic t_no_write();
        @(negedge clk);
        bus_addr  = mk(2, 9);
        bus_wdata = 32'h5555_AAAA;
        bus_we    = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "fsel port2 held", 192'(pin_fsel[95:64]), 192'(mdl[2][9]));
        @(negedge clk);
        bus_we = 1'b1;
        #1;
        chk("R8", "fsel before edge", 192'(pin_fsel[95:64]), 192'(mdl[2][9]));
        @(negedge clk);
        bus_we = 1'b0;
        mdl[2][9] = 32'h5555_AAAA;
        #1;
        chk("R8", "fsel after edge", 192'(pin_fsel[95:64]), 192'(32'h5555_AAAA));
        check_state("R8");
    endtask

    initial begin
        for (int p = 0; p < NP; p++)
            for (int r = 0; r < NREG; r++)
                mdl[p][r] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "pin_gpio in reset", 192'(pin_gpio), 192'(0));
        rst_n = 1'b1;
        t_reset();
        t_one_bit();
        t_two_bit();
        t_input_cfg();
        t_port_isolation();
        t_comb_read();
        t_unmapped();
        t_no_write();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule